// File: doc/BRIEF.md
# Randomized Remapping Cache

This block is a small read-only cache that has no fixed set decoder. Each physical line owns a mapping register. That register records which logical line the physical line currently stands for. The logical index is wider than the physical index, and it is qualified by a remapping-table identifier. A lookup compares the request against every mapping register at once. When no register matches, a physical line chosen at random is taken over, so the mapping from memory to cache keeps changing. When one register matches, the block acts like a direct-mapped cache on that line. A tag mismatch on that line then gives a conflict miss.

Every request carries a word address, a table identifier and a protection bit; the protection bit comes from the page that holds the address. A static mode input selects one of two policies.

- **Tag-side policy (`modeImproved` = 0):** the protection bit is stored next to the tag. When a conflict miss involves protected data, the cache serves the fetched data without installing it, and a random line is thrown out instead.
- **Key-side policy (`modeImproved` = 1):** the protection bit becomes part of the mapping key. A protection mismatch then counts as an index miss.

Only one miss may be outstanding. Misses are fetched over a simple line-wide memory port.

Top module: `remap_cache`

## Requirements
- R1: After reset no mapping register and no line is valid. `reqReady` is 1 and `respValid` and `memReqValid` are 0. The first access after reset is an index miss.
- R2: With the default sizes, `reqAddr` is a word address split as follows: bits [2:0] select the 32-bit word within a 32-byte line, bits [9:3] are the 7-bit logical index (3 physical bits plus 4 extra), and bits [13:10] are the tag. A mapping register matches when it is valid and both its logical index and its table ID equal the request's.
- R3: If no register matches (index miss), the victim is the physical line whose number equals the low bits of the random generator in the acceptance cycle. That line's mapping register takes the request's index, table ID and protection bit, and the fetched line is installed there.
- R4: If the matched line holds the request's tag, the access is a hit. `respValid` and `respHit` rise in the cycle after acceptance, carrying the addressed word, and no memory request is made.
- R5: A conflict miss (match, tag differs) that is not bypassed refills the matched line in place with the new tag and protection bit.
- R6: In tag-side mode, a conflict miss where either the request or the resident line is protected installs nothing. The data still goes to the requester, and the mapping register and line at the random victim number are invalidated.
- R7: In key-side mode, the protection bit is part of the match key. An access that differs from a resident mapping only in its protection bit is an index miss.
- R8: While a miss is pending, `reqReady` is 0. It returns to 1 in the cycle after the fill response.
- R9: On a miss, `memReqValid` asserts in the cycle after acceptance with `memReqAddr` = `reqAddr`[13:3]. It stays asserted until `memReqReady` is sampled high. The addressed word of `memRespData` (word n at bits [32n+31:32n]) appears on `respData` in the same cycle as `memRespValid`.
- R10: The random generator is a 16-bit register, loaded with the seed parameter at reset. On every clock it shifts left and takes in bit 15 ^ bit 13 ^ bit 12 ^ bit 10 at bit 0.
- R11: Whenever `respValid` is 1, exactly one of `respHit`, `respIdxMiss` and `respTagMiss` is 1. `respIdxMiss` and `respTagMiss` are given with the fill response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeImproved | input | 1 | 1 selects the key-side protection policy; change only under reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | 14 | Word address |
| reqTable | input | 2 | Remapping-table identifier |
| reqProt | input | 1 | Protection attribute of the addressed page |
| respValid | output | 1 | Response data valid |
| respData | output | 32 | Addressed word |
| respHit | output | 1 | Response came from a hit |
| respIdxMiss | output | 1 | Response came from an index miss |
| respTagMiss | output | 1 | Response came from a conflict miss |
| memReqValid | output | 1 | Line fetch request |
| memReqReady | input | 1 | Memory takes the fetch request |
| memReqAddr | output | 11 | Line address to fetch |
| memRespValid | input | 1 | Fetched line present |
| memRespData | input | 256 | Fetched line |

## Verification
A corrupted mapping register or line state does not show up at once. It shows as a wrong hit, index-miss or conflict-miss flag on the next access that touches that logical line. That access may come many requests later. A wrong victim number shows only when an unrelated line, expected to survive, later misses or hits unexpectedly.

The bench therefore runs a full reference model of every mapping register and line, driven by the same random sequence. It also checks the status flags and the data on every single access, so any divergence is reported at the first access it affects.

// File: rtl/remap_cache_pkg.sv
package remap_cache_pkg;

  // classification of one lookup
  typedef enum logic [1:0] {
    LK_HIT      = 2'd0,
    LK_IDX_MISS = 2'd1,
    LK_TAG_MISS = 2'd2
  } lookup_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch request, match result and victim number
    logic fillVictim; // remap and fill the random victim line
    logic fillMatch;  // refill the matched line in place
    logic dropVictim; // invalidate the random victim line, install nothing
    logic selMem;     // response word comes from the memory bus
  } dp_strobe_t;

  localparam int unsigned LfsrWidth = 16;

endpackage

// File: rtl/remap_cache_lfsr.sv
module remap_cache_lfsr
  import remap_cache_pkg::*;
#(
  parameter logic [LfsrWidth-1:0] SEED  = 16'hACE1,
  parameter int unsigned          OUT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [OUT_W-1:0] rnd
);

  logic [LfsrWidth-1:0] lfsrState;
  logic                 feedback;

  assign feedback = lfsrState[15] ^ lfsrState[13] ^ lfsrState[12] ^ lfsrState[10];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsrState <= SEED;
    else       lfsrState <= {lfsrState[LfsrWidth-2:0], feedback};
  end

  assign rnd = lfsrState[OUT_W-1:0];

  // R10: a maximal-length sequence never reaches the all-zero lock-up state
  a_r10_never_zero: assert property (@(posedge clk) disable iff (!rstN)
    lfsrState != '0);

endmodule

// File: rtl/remap_cache_ctrl.sv
module remap_cache_ctrl
  import remap_cache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  input  lookup_kind_e lookupKind,
  input  logic         lookupBypass,
  output logic         memReqValid,
  input  logic         memReqReady,
  input  logic         memRespValid,
  output logic         respValid,
  output logic         respHit,
  output logic         respIdxMiss,
  output logic         respTagMiss,
  output dp_strobe_t   strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_ASK, ST_WAIT} ctrl_state_e;

  ctrl_state_e  state;
  lookup_kind_e kindQ;
  logic         bypassQ;
  logic         hitPendQ;
  logic         accept;
  logic         fillNow;

  assign accept  = reqValid && (state == ST_IDLE);
  assign fillNow = (state == ST_WAIT) && memRespValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      kindQ    <= LK_HIT;
      bypassQ  <= 1'b0;
      hitPendQ <= 1'b0;
    end else begin
      hitPendQ <= accept && (lookupKind == LK_HIT);
      unique case (state)
        ST_IDLE: if (accept) begin
          kindQ   <= lookupKind;
          bypassQ <= lookupBypass;
          if (lookupKind != LK_HIT) state <= ST_ASK;
        end
        ST_ASK:  if (memReqReady) state <= ST_WAIT;
        ST_WAIT: if (memRespValid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_ASK);

  always_comb begin
    strb            = '0;
    strb.capture    = accept;
    strb.fillVictim = fillNow && (kindQ == LK_IDX_MISS);
    strb.fillMatch  = fillNow && (kindQ == LK_TAG_MISS) && !bypassQ;
    strb.dropVictim = fillNow && (kindQ == LK_TAG_MISS) && bypassQ;
    strb.selMem     = (state == ST_WAIT);
  end

  assign respValid   = hitPendQ || fillNow;
  assign respHit     = hitPendQ;
  assign respIdxMiss = fillNow && (kindQ == LK_IDX_MISS);
  assign respTagMiss = fillNow && (kindQ == LK_TAG_MISS);

  // R9: a fetch request is held until memory takes it
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

  // R8: no new request is taken while a fetch is in flight
  a_r8_stall_while_pending: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !reqReady);

  // R11: each response carries exactly one classification
  a_r11_one_flag: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $countones({respHit, respIdxMiss, respTagMiss}) == 1);

  // R4: a hit answer follows an accepted request by one cycle
  a_r4_hit_timing: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> $past(reqValid && reqReady));

endmodule

// File: rtl/remap_cache_dp.sv
module remap_cache_dp
  import remap_cache_pkg::*;
#(
  parameter  int unsigned LINES      = 8,
  parameter  int unsigned EXTRA_BITS = 4,
  parameter  int unsigned ADDR_W     = 16,
  parameter  int unsigned LINE_BYTES = 32,
  parameter  int unsigned WORD_W     = 32,
  parameter  int unsigned TABLE_W    = 2,
  localparam int unsigned BSEL_W     = $clog2(WORD_W / 8),
  localparam int unsigned WADDR_W    = ADDR_W - BSEL_W,
  localparam int unsigned LINE_W     = LINE_BYTES * 8,
  localparam int unsigned WSEL_W     = $clog2(LINE_W / WORD_W),
  localparam int unsigned PIDX_W     = $clog2(LINES),
  localparam int unsigned LIDX_W     = PIDX_W + EXTRA_BITS,
  localparam int unsigned TAG_W      = WADDR_W - WSEL_W - LIDX_W,
  localparam int unsigned LADDR_W    = TAG_W + LIDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeImproved,
  input  logic [WADDR_W-1:0] reqAddr,
  input  logic [TABLE_W-1:0] reqTable,
  input  logic               reqProt,
  input  logic [PIDX_W-1:0]  rnd,
  input  dp_strobe_t         strb,
  output lookup_kind_e       lookupKind,
  output logic               lookupBypass,
  output logic [LADDR_W-1:0] memLineAddr,
  input  logic [LINE_W-1:0]  memRespData,
  output logic [WORD_W-1:0]  respData
);

  // request fields
  logic [WSEL_W-1:0] reqWsel;
  logic [LIDX_W-1:0] reqLidx;
  logic [TAG_W-1:0]  reqTag;

  assign reqWsel = reqAddr[WSEL_W-1:0];
  assign reqLidx = reqAddr[WSEL_W +: LIDX_W];
  assign reqTag  = reqAddr[WSEL_W+LIDX_W +: TAG_W];

  // mapping registers and lines
  logic [LINES-1:0]   mapValid;
  logic [LINES-1:0]   mapProt;
  logic [LIDX_W-1:0]  mapLidx  [LINES];
  logic [TABLE_W-1:0] mapTable [LINES];
  logic [LINES-1:0]   lineValid;
  logic [LINES-1:0]   lineProt;
  logic [TAG_W-1:0]   lineTag  [LINES];
  logic [LINE_W-1:0]  lineData [LINES];

  // captured request
  logic [LIDX_W-1:0]  lidxQ;
  logic [TAG_W-1:0]   tagQ;
  logic [WSEL_W-1:0]  wselQ;
  logic               protQ;
  logic [TABLE_W-1:0] tableQ;
  logic [PIDX_W-1:0]  matchIdxQ;
  logic [PIDX_W-1:0]  victimQ;
  logic [WORD_W-1:0]  hitWordQ;

  // parallel match over all mapping registers
  logic [LINES-1:0]  match;
  logic [PIDX_W-1:0] matchIdx;

  for (genvar g = 0; g < LINES; g++) begin : g_match
    assign match[g] = mapValid[g]
                   && (mapLidx[g] == reqLidx)
                   && (mapTable[g] == reqTable)
                   && (!modeImproved || (mapProt[g] == reqProt));
  end

  always_comb begin
    matchIdx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (match[i]) matchIdx = PIDX_W'(i);
    end
  end

  always_comb begin
    if (!(|match))
      lookupKind = LK_IDX_MISS;
    else if (lineValid[matchIdx] && (lineTag[matchIdx] == reqTag))
      lookupKind = LK_HIT;
    else
      lookupKind = LK_TAG_MISS;
  end

  assign lookupBypass = !modeImproved && (reqProt || lineProt[matchIdx]);

  // capture at acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lidxQ     <= '0;
      tagQ      <= '0;
      wselQ     <= '0;
      protQ     <= 1'b0;
      tableQ    <= '0;
      matchIdxQ <= '0;
      victimQ   <= '0;
      hitWordQ  <= '0;
    end else if (strb.capture) begin
      lidxQ     <= reqLidx;
      tagQ      <= reqTag;
      wselQ     <= reqWsel;
      protQ     <= reqProt;
      tableQ    <= reqTable;
      matchIdxQ <= matchIdx;
      victimQ   <= rnd;
      hitWordQ  <= lineData[matchIdx][int'(reqWsel)*WORD_W +: WORD_W];
    end
  end

  // valid bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapValid  <= '0;
      lineValid <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (strb.fillVictim && (victimQ == PIDX_W'(i))) begin
          mapValid[i]  <= 1'b1;
          lineValid[i] <= 1'b1;
        end else if (strb.dropVictim && (victimQ == PIDX_W'(i))) begin
          mapValid[i]  <= 1'b0;
          lineValid[i] <= 1'b0;
        end else if (strb.fillMatch && (matchIdxQ == PIDX_W'(i))) begin
          lineValid[i] <= 1'b1;
        end
      end
    end
  end

  // payload, not reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (strb.fillVictim && (victimQ == PIDX_W'(i))) begin
        mapLidx[i]  <= lidxQ;
        mapTable[i] <= tableQ;
        mapProt[i]  <= protQ;
      end
      if ((strb.fillVictim && (victimQ == PIDX_W'(i))) ||
          (strb.fillMatch && (matchIdxQ == PIDX_W'(i)))) begin
        lineTag[i]  <= tagQ;
        lineProt[i] <= protQ;
        lineData[i] <= memRespData;
      end
    end
  end

  assign memLineAddr = {tagQ, lidxQ};
  assign respData    = strb.selMem ? memRespData[int'(wselQ)*WORD_W +: WORD_W] : hitWordQ;

  // R2: with the mode fixed since reset, at most one mapping register matches
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(match));

  // R3: an index-miss fill leaves the victim mapped and valid
  a_r3_victim_mapped: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillVictim |=> mapValid[victimQ] && lineValid[victimQ] && (mapLidx[victimQ] == lidxQ));

  // R3: a valid mapping always points at a valid line
  a_r3_map_has_line: assert property (@(posedge clk) disable iff (!rstN)
    (mapValid & ~lineValid) == '0);

  // R5: an in-place refill holds the new tag
  a_r5_refill_in_place: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillMatch |=> lineValid[matchIdxQ] && (lineTag[matchIdxQ] == tagQ));

  // R6: a bypassed conflict miss empties the random victim
  a_r6_drop_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.dropVictim |=> !mapValid[victimQ] && !lineValid[victimQ]);

endmodule

// File: rtl/remap_cache.sv
module remap_cache
  import remap_cache_pkg::*;
#(
  parameter  int unsigned          LINES      = 8,
  parameter  int unsigned          EXTRA_BITS = 4,
  parameter  int unsigned          ADDR_W     = 16,
  parameter  int unsigned          LINE_BYTES = 32,
  parameter  int unsigned          WORD_W     = 32,
  parameter  int unsigned          TABLE_W    = 2,
  parameter  logic [LfsrWidth-1:0] LFSR_SEED  = 16'hACE1,
  localparam int unsigned          WADDR_W    = ADDR_W - $clog2(WORD_W / 8),
  localparam int unsigned          LADDR_W    = ADDR_W - $clog2(LINE_BYTES),
  localparam int unsigned          LINE_W     = LINE_BYTES * 8,
  localparam int unsigned          PIDX_W     = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeImproved,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [WADDR_W-1:0] reqAddr,
  input  logic [TABLE_W-1:0] reqTable,
  input  logic               reqProt,
  output logic               respValid,
  output logic [WORD_W-1:0]  respData,
  output logic               respHit,
  output logic               respIdxMiss,
  output logic               respTagMiss,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [LADDR_W-1:0] memReqAddr,
  input  logic               memRespValid,
  input  logic [LINE_W-1:0]  memRespData
);

  dp_strobe_t        strb;
  lookup_kind_e      lookupKind;
  logic              lookupBypass;
  logic [PIDX_W-1:0] rnd;

  remap_cache_lfsr #(
    .SEED  (LFSR_SEED),
    .OUT_W (PIDX_W)
  ) i_lfsr (
    .clk  (clk),
    .rstN (rstN),
    .rnd  (rnd)
  );

  remap_cache_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqReady     (reqReady),
    .lookupKind   (lookupKind),
    .lookupBypass (lookupBypass),
    .memReqValid  (memReqValid),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .respValid    (respValid),
    .respHit      (respHit),
    .respIdxMiss  (respIdxMiss),
    .respTagMiss  (respTagMiss),
    .strb         (strb)
  );

  remap_cache_dp #(
    .LINES      (LINES),
    .EXTRA_BITS (EXTRA_BITS),
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .WORD_W     (WORD_W),
    .TABLE_W    (TABLE_W)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .modeImproved (modeImproved),
    .reqAddr      (reqAddr),
    .reqTable     (reqTable),
    .reqProt      (reqProt),
    .rnd          (rnd),
    .strb         (strb),
    .lookupKind   (lookupKind),
    .lookupBypass (lookupBypass),
    .memLineAddr  (memReqAddr),
    .memRespData  (memRespData),
    .respData     (respData)
  );

endmodule

// File: tb/test_remap_cache.sv
`timescale 1ns/1ps
module test_remap_cache;

  localparam int LINES = 8;
  localparam logic [15:0] SEED = 16'hACE1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         modeImproved = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [13:0]  reqAddr = '0;
  logic [1:0]   reqTable = '0;
  logic         reqProt = 1'b0;
  logic         respValid;
  logic [31:0]  respData;
  logic         respHit, respIdxMiss, respTagMiss;
  logic         memReqValid;
  logic         memReqReady = 1'b0;
  logic [10:0]  memReqAddr;
  logic         memRespValid = 1'b0;
  logic [255:0] memRespData = '0;

  remap_cache #(.LFSR_SEED(SEED)) i_remap_cache (
    .clk(clk), .rstN(rstN), .modeImproved(modeImproved),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqTable(reqTable), .reqProt(reqProt),
    .respValid(respValid), .respData(respData), .respHit(respHit),
    .respIdxMiss(respIdxMiss), .respTagMiss(respTagMiss),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData)
  );

  always #4 clk = ~clk;

  // random sequence as defined by R10
  logic [15:0] refLfsr;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) refLfsr <= SEED;
    else       refLfsr <= {refLfsr[14:0], refLfsr[15] ^ refLfsr[13] ^ refLfsr[12] ^ refLfsr[10]};
  end

  // reference state
  int mV[LINES], mL[LINES], mT[LINES], mP[LINES];
  int lV[LINES], lTag[LINES], lP[LINES];
  int vectors = 0;
  int miscompares = 0;
  bit improved = 1'b0;

  function automatic logic [31:0] memWord(int la, int w);
    return (32'(la) * 32'h9E37_79B1) + (32'(w) * 32'h0101_0101) + 32'h5A00_00A5;
  endfunction

  function automatic logic [255:0] memLine(int la);
    logic [255:0] r;
    for (int w = 0; w < 8; w++) r[w*32 +: 32] = memWord(la, w);
    return r;
  endfunction

  task automatic checkEq(string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic applyReset(bit mode);
    @(negedge clk);
    rstN = 1'b0;
    modeImproved = mode;
    improved = mode;
    for (int i = 0; i < LINES; i++) begin
      mV[i] = 0; lV[i] = 0; mL[i] = 0; mT[i] = 0; mP[i] = 0; lTag[i] = 0; lP[i] = 0;
    end
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "reqReady after reset", 64'(reqReady), 64'd1);
    checkEq("R1", "respValid after reset", 64'(respValid), 64'd0);
    checkEq("R1", "memReqValid after reset", 64'(memReqValid), 64'd0);
  endtask

  // one access, called at a falling edge with the block idle
  task automatic doAccess(int tag, int lidx, int w, int t, int p);
    int wa, la, hitI, kind, vic, bypass;
    string rq;
    wa = (tag << 10) | (lidx << 3) | w;
    la = wa >> 3;
    hitI = -1;
    for (int i = 0; i < LINES; i++)
      if (mV[i] != 0 && mL[i] == lidx && mT[i] == t && (!improved || mP[i] == p)) hitI = i;
    vic = int'(refLfsr) & (LINES - 1);
    if (hitI < 0) kind = 1;
    else if (lV[hitI] != 0 && lTag[hitI] == tag) kind = 0;
    else kind = 2;
    bypass = (kind == 2 && !improved && (p != 0 || lP[hitI] != 0)) ? 1 : 0;
    if (kind == 0) rq = "R4";
    else if (kind == 1) rq = improved ? "R7/R3/R10" : "R3/R10";
    else if (bypass != 0) rq = "R6";
    else rq = improved ? "R7/R5" : "R5";

    reqValid = 1'b1; reqAddr = 14'(wa); reqTable = 2'(t); reqProt = p[0];
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (kind == 0) begin
      checkEq(rq, "hit respValid", 64'(respValid), 64'd1);
      checkEq(rq, "flags {hit,idx,tag}", 64'({respHit, respIdxMiss, respTagMiss}), 64'b100);
      checkEq(rq, "hit data", 64'(respData), 64'(memWord(la, w)));
      checkEq(rq, "no fetch on hit", 64'(memReqValid), 64'd0);
    end else begin
      checkEq(rq, "no early response", 64'(respValid), 64'd0);
      checkEq("R8", "reqReady while pending", 64'(reqReady), 64'd0);
      checkEq("R9", "memReqValid", 64'(memReqValid), 64'd1);
      checkEq("R9", "memReqAddr", 64'(memReqAddr), 64'(la));
      @(negedge clk);
      checkEq("R9", "request held", 64'(memReqValid), 64'd1);
      memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
      checkEq("R9", "request dropped after take", 64'(memReqValid), 64'd0);
      checkEq("R8", "reqReady while waiting", 64'(reqReady), 64'd0);
      @(negedge clk);
      memRespValid = 1'b1;
      memRespData = memLine(la);
      #1;
      checkEq("R9", "respValid with fill", 64'(respValid), 64'd1);
      checkEq("R9", "fill data", 64'(respData), 64'(memWord(la, w)));
      checkEq(rq, "flags {hit,idx,tag}", 64'({respHit, respIdxMiss, respTagMiss}),
              (kind == 1) ? 64'b010 : 64'b001);
      checkEq("R11", "one flag", 64'($countones({respHit, respIdxMiss, respTagMiss})), 64'd1);
      @(negedge clk);
      memRespValid = 1'b0;
      checkEq("R8", "reqReady after fill", 64'(reqReady), 64'd1);
      if (kind == 1) begin
        mV[vic] = 1; mL[vic] = lidx; mT[vic] = t; mP[vic] = p;
        lV[vic] = 1; lTag[vic] = tag; lP[vic] = p;
      end else if (bypass != 0) begin
        mV[vic] = 0; lV[vic] = 0;
      end else begin
        lV[hitI] = 1; lTag[hitI] = tag; lP[hitI] = p;
      end
    end
  endtask

  task automatic sweep(int count, int salt);
    for (int n = 0; n < count; n++) begin
      doAccess((n * 7 + n / 5 + salt) % 4, (n * 5 + salt) % 12, n % 8,
               (n / 7) % 2, (n / 3 + salt) % 2);
    end
  endtask

  initial begin
    // tag-side policy
    applyReset(1'b0);
    doAccess(1, 3, 2, 0, 0);   // R1: first access is an index miss
    doAccess(1, 3, 2, 0, 0);   // R4 hit
    doAccess(1, 3, 5, 0, 0);   // R4 hit, other word
    doAccess(2, 3, 0, 0, 0);   // R5 conflict miss
    doAccess(2, 3, 7, 0, 0);   // R5 refilled line hits
    doAccess(1, 3, 2, 0, 0);   // R5 conflict again
    doAccess(1, 3, 2, 1, 0);   // R2 other table: index miss
    doAccess(1, 9, 1, 0, 1);   // protected index miss
    doAccess(3, 9, 4, 0, 1);   // R6 bypassed conflict
    doAccess(3, 9, 4, 0, 1);   // R6 not installed
    doAccess(1, 9, 6, 0, 0);   // R6 resident protected line, plain request
    sweep(220, 0);

    // key-side policy
    applyReset(1'b1);
    doAccess(1, 5, 3, 0, 0);   // index miss
    doAccess(1, 5, 3, 0, 1);   // R7 prot differs: index miss
    doAccess(1, 5, 3, 0, 0);   // R7 plain mapping still separate
    doAccess(2, 5, 0, 0, 1);   // R7 conflict refills in place
    doAccess(2, 5, 1, 0, 1);
    sweep(220, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule